// File: doc/BRIEF.md
# Synchronous Byte Transmitter with CRC-16 Append

This block is a byte-oriented synchronous serial transmitter. The host places characters into a one-entry holding buffer. A shifter drains the buffer one bit per pulse of a transmit bit-enable. When the transmitter is enabled and has no data, it fills the line with a programmed sync character. Every character that carries data can take part in a running CRC-16. Whether a character takes part is decided by a CRC-enable input, sampled at the moment the character moves from the buffer into the shifter.

When the shifter needs its next character and the buffer is empty after data has been sent, the block has an underrun. It sets an underrun/end-of-message status latch. If the host cleared that latch during the message, the block appends the complemented CRC as two bytes and then returns to sync fill. If the latch was still set, the block sends only sync. A 0-to-1 change of the latch can raise a one-cycle interrupt pulse. The clear command for the latch has no effect while the transmitter is disabled.

Top module: `sync_tx`

## Requirements
- R1: During reset, `txd_o` is 1, `buf_empty_o` is 1, `eom_o` is 1 and `irq_o` is 0. Whenever `tx_en_i` is low, the line idles at 1 and the holding buffer is emptied.
- R2: After `tx_en_i` rises with an empty buffer, the block sends `sync_char_i` back to back. These leading sync characters never enter the CRC.
- R3: A write on `wr_i` is taken only when `tx_en_i` is high and `buf_empty_o` is 1. A write that is taken drives `buf_empty_o` low until the character moves into the shifter. A write in any other cycle is ignored.
- R4: Characters leave LSB first, one bit per `bit_en_i` pulse. They follow each other with no gap and keep the order in which they were written.
- R5: The CRC uses polynomial 0x1021 and is preset to 0xFFFF on enable and after each underrun. For each character, the CRC steps over bits 0 to 7 in turn: feedback = crc[15] XOR bit, then crc shifts left by one and is XORed with 0x1021 when feedback is 1. Only characters whose `crc_en_i` was high when they moved into the shifter are included, so a data byte equal to the sync pattern is included or skipped according to that bit.
- R6: On underrun with the latch cleared, the block sends ~crc[15:8] and then ~crc[7:0], each LSB first, and then sync. `eom_o` returns to 1.
- R7: On underrun with the latch still set, the last data byte is followed directly by sync, with no CRC bytes.
- R8: `eom_clr_i` clears `eom_o` only while `tx_en_i` is high. While the transmitter is disabled, it leaves `eom_o` unchanged.
- R9: `irq_o` pulses for exactly the first cycle in which `eom_o` is 1 after being 0, and only when `irq_en_i` is high. It is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable |
| bit_en_i | input | 1 | One-cycle pulse per transmit bit time |
| wr_i | input | 1 | Holding buffer write strobe |
| wr_data_i | input | 8 | Character to write |
| crc_en_i | input | 1 | CRC inclusion for the character being moved into the shifter |
| sync_char_i | input | 8 | Sync fill pattern |
| eom_clr_i | input | 1 | Command strobe that clears the underrun/EOM latch |
| irq_en_i | input | 1 | Interrupt enable for the latch rising edge |
| txd_o | output | 1 | Serial data out |
| buf_empty_o | output | 1 | Holding buffer can take a write |
| eom_o | output | 1 | Underrun/EOM status latch |
| irq_o | output | 1 | Status interrupt pulse |

## Verification
Several behaviours are checked by the assertions on every clock cycle:
- the line idles and the buffer empties while disabled;
- the line holds steady between bit pulses;
- an accepted write fills the buffer;
- the latch stays frozen while disabled;
- the interrupt appears exactly on the latch's rising edge when it is enabled.

Other behaviours can only be shown by the bench's scenarios, because they depend on byte streams rebuilt from the line. These are the CRC value, the choice between CRC append and plain sync at underrun, per-character CRC exclusion of a data byte that matches the sync pattern, and the dropping of a second write into a full buffer.

// File: rtl/sync_tx_pkg.sv
package sync_tx_pkg;
  typedef enum logic [1:0] {
    SRC_SYNC   = 2'd0,
    SRC_DATA   = 2'd1,
    SRC_CRC_HI = 2'd2,
    SRC_CRC_LO = 2'd3
  } src_e;
endpackage

// File: rtl/sync_tx_buf.sv
module sync_tx_buf #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              wr_i,
  input  logic [CHAR_W-1:0] wr_data_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic [CHAR_W-1:0] data_o
);
  logic              full_q;
  logic [CHAR_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (!tx_en_i) begin
      full_q <= 1'b0;
    end else if (pop_i && full_q) begin
      full_q <= 1'b0;
    end else if (wr_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= wr_data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/sync_tx_crc.sv
module sync_tx_crc #(
  parameter int unsigned       CHAR_W = 8,
  parameter int unsigned       CRC_W  = 16,
  parameter logic [CRC_W-1:0]  POLY   = 16'h1021,
  parameter logic [CRC_W-1:0]  INIT   = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              acc_i,
  input  logic [CHAR_W-1:0] acc_data_i,
  input  logic              preset_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nxt;

  // whole character folded in one cycle, bit 0 first
  always_comb begin
    logic fb;
    crc_nxt = crc_q;
    for (int k = 0; k < int'(CHAR_W); k++) begin
      fb      = crc_nxt[CRC_W-1] ^ acc_data_i[k];
      crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            crc_q <= INIT;
    else if (!tx_en_i)      crc_q <= INIT;
    else if (preset_i)      crc_q <= INIT;
    else if (acc_i)         crc_q <= crc_nxt;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/sync_tx_status.sv
module sync_tx_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic eom_o,
  output logic irq_o
);
  logic eom_q, eom_d1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eom_q    <= 1'b1;
      eom_d1_q <= 1'b1;
    end else begin
      eom_d1_q <= eom_q;
      if (set_i)                eom_q <= 1'b1;
      else if (clr_i && tx_en_i) eom_q <= 1'b0;
    end
  end

  assign eom_o = eom_q;
  assign irq_o = eom_q & ~eom_d1_q & irq_en_i;
endmodule

// File: rtl/sync_tx_seq.sv
module sync_tx_seq
  import sync_tx_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned CRC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              bit_en_i,
  input  logic              buf_full_i,
  input  logic [CHAR_W-1:0] buf_data_i,
  input  logic              crc_en_i,
  input  logic [CHAR_W-1:0] sync_char_i,
  input  logic [CRC_W-1:0]  crc_i,
  input  logic              eom_i,
  output logic              pop_o,
  output logic              acc_o,
  output logic              preset_o,
  output logic              eom_set_o,
  output logic              sh_valid_o,
  output logic              txd_o
);
  localparam int unsigned CNT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CHAR_W - 1);

  logic [CHAR_W-1:0] sh_q, lo_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sh_valid_q, in_msg_q, lo_pend_q;
  logic              last_bit, load, underrun;
  src_e              src;
  logic [CHAR_W-1:0] load_char;

  assign last_bit = bit_en_i && (cnt_q == CNT_LAST);
  assign load     = tx_en_i && (!sh_valid_q || last_bit);

  always_comb begin
    if (lo_pend_q)                src = SRC_CRC_LO;
    else if (buf_full_i)          src = SRC_DATA;
    else if (in_msg_q && !eom_i)  src = SRC_CRC_HI;
    else                          src = SRC_SYNC;
  end

  always_comb begin
    unique case (src)
      SRC_DATA:   load_char = buf_data_i;
      SRC_CRC_HI: load_char = ~crc_i[CRC_W-1 -: CHAR_W];
      SRC_CRC_LO: load_char = lo_q;
      default:    load_char = sync_char_i;
    endcase
  end

  assign underrun  = load && !lo_pend_q && !buf_full_i && in_msg_q;
  assign pop_o     = load && (src == SRC_DATA);
  assign acc_o     = pop_o && crc_en_i;
  assign preset_o  = underrun;
  assign eom_set_o = underrun;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q       <= '0;
      lo_q       <= '0;
      cnt_q      <= '0;
      sh_valid_q <= 1'b0;
      in_msg_q   <= 1'b0;
      lo_pend_q  <= 1'b0;
    end else if (!tx_en_i) begin
      cnt_q      <= '0;
      sh_valid_q <= 1'b0;
      in_msg_q   <= 1'b0;
      lo_pend_q  <= 1'b0;
    end else if (load) begin
      sh_q       <= load_char;
      cnt_q      <= '0;
      sh_valid_q <= 1'b1;
      if (src == SRC_DATA) in_msg_q <= 1'b1;
      else if (underrun)   in_msg_q <= 1'b0;
      if (src == SRC_CRC_HI) begin
        lo_pend_q <= 1'b1;
        lo_q      <= ~crc_i[CHAR_W-1:0];
      end else if (src == SRC_CRC_LO) begin
        lo_pend_q <= 1'b0;
      end
    end else if (bit_en_i) begin
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sh_valid_o = sh_valid_q;
  assign txd_o      = sh_valid_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/sync_tx.sv
module sync_tx #(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned CRC_W  = 16,
  parameter logic [15:0] POLY   = 16'h1021,
  parameter logic [15:0] INIT   = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              bit_en_i,
  input  logic              wr_i,
  input  logic [CHAR_W-1:0] wr_data_i,
  input  logic              crc_en_i,
  input  logic [CHAR_W-1:0] sync_char_i,
  input  logic              eom_clr_i,
  input  logic              irq_en_i,
  output logic              txd_o,
  output logic              buf_empty_o,
  output logic              eom_o,
  output logic              irq_o
);
  logic              buf_full, pop, acc, preset, eom_set, sh_valid;
  logic [CHAR_W-1:0] buf_data;
  logic [CRC_W-1:0]  crc;

  sync_tx_buf #(.CHAR_W(CHAR_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_en_i   (tx_en_i),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .pop_i     (pop),
    .full_o    (buf_full),
    .data_o    (buf_data)
  );

  sync_tx_crc #(
    .CHAR_W (CHAR_W),
    .CRC_W  (CRC_W),
    .POLY   (CRC_W'(POLY)),
    .INIT   (CRC_W'(INIT))
  ) u_crc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en_i),
    .acc_i      (acc),
    .acc_data_i (buf_data),
    .preset_i   (preset),
    .crc_o      (crc)
  );

  sync_tx_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tx_en_i  (tx_en_i),
    .set_i    (eom_set),
    .clr_i    (eom_clr_i),
    .irq_en_i (irq_en_i),
    .eom_o    (eom_o),
    .irq_o    (irq_o)
  );

  sync_tx_seq #(.CHAR_W(CHAR_W), .CRC_W(CRC_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_en_i     (tx_en_i),
    .bit_en_i    (bit_en_i),
    .buf_full_i  (buf_full),
    .buf_data_i  (buf_data),
    .crc_en_i    (crc_en_i),
    .sync_char_i (sync_char_i),
    .crc_i       (crc),
    .eom_i       (eom_o),
    .pop_o       (pop),
    .acc_o       (acc),
    .preset_o    (preset),
    .eom_set_o   (eom_set),
    .sh_valid_o  (sh_valid),
    .txd_o       (txd_o)
  );

  assign buf_empty_o = ~buf_full;
endmodule

// File: rtl/sync_tx_chk.sv
module sync_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic bit_en_i,
  input logic wr_i,
  input logic irq_en_i,
  input logic sh_valid_i,
  input logic txd_o,
  input logic buf_empty_o,
  input logic eom_o,
  input logic irq_o
);
  p_idle_line_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> txd_o);

  p_buf_cleared_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> buf_empty_o);

  p_write_fills_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && wr_i && buf_empty_o) |=> !buf_empty_o);

  p_txd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && sh_valid_i && !bit_en_i) |=> $stable(txd_o));

  p_eom_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> $stable(eom_o));

  p_irq_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (eom_o && irq_en_i && $rose(eom_o)));

  p_irq_on_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(eom_o) && irq_en_i) |-> irq_o);
endmodule

bind sync_tx sync_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_en_i     (tx_en_i),
  .bit_en_i    (bit_en_i),
  .wr_i        (wr_i),
  .irq_en_i    (irq_en_i),
  .sh_valid_i  (sh_valid),
  .txd_o       (txd_o),
  .buf_empty_o (buf_empty_o),
  .eom_o       (eom_o),
  .irq_o       (irq_o)
);

// File: tb/sync_tx_tb_top.sv
`timescale 1ns/100ps
module sync_tx_tb_top;
  localparam logic [7:0] SYNC = 8'h3C;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_ni, tx_en, bit_en, wr, crc_en, eom_clr, irq_en;
  logic [7:0] wr_data, sync_char;
  logic       txd_o, buf_empty_o, eom_o, irq_o;

  sync_tx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en), .bit_en_i(bit_en),
    .wr_i(wr), .wr_data_i(wr_data), .crc_en_i(crc_en), .sync_char_i(sync_char),
    .eom_clr_i(eom_clr), .irq_en_i(irq_en),
    .txd_o(txd_o), .buf_empty_o(buf_empty_o), .eom_o(eom_o), .irq_o(irq_o)
  );

  int checks = 0, errors = 0, irq_cnt = 0;
  bit done = 0;
  logic [7:0] rxb[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_model(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[15] ^ d[k]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  // bit-time pulse, one cycle in four
  initial begin
    int ph = 0;
    bit_en = 1'b0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      bit_en = (ph == 0);
    end
  end

  // line monitor, sampled late in each cycle
  initial begin
    bit prev_en = 0;
    int bitcnt = 0;
    logic [7:0] sr = '0;
    forever begin
      @(negedge clk); #1;
      if (tx_en && prev_en && bit_en) begin
        sr = {txd_o, sr[7:1]};
        bitcnt++;
        if (bitcnt == 8) begin
          rxb.push_back(sr);
          bitcnt = 0;
        end
      end
      if (!tx_en) bitcnt = 0;
      if (irq_o) irq_cnt++;
      prev_en = tx_en;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d, input bit ce);
    @(negedge clk);
    while (!buf_empty_o) @(negedge clk);
    wr = 1'b1; wr_data = d; crc_en = ce;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic msg(input int n, input int seed, input bit clr, input bit ie, input bit sync_mid);
    logic [7:0]  d[4];
    bit          ce[4];
    logic [15:0] c = 16'hFFFF;
    int          idx = 0;
    tx_en = 1'b0; irq_en = ie;
    cycles(3);
    rxb.delete(); irq_cnt = 0;
    tx_en = 1'b1;
    cycles(40);
    for (int i = 0; i < n; i++) begin
      d[i]  = 8'((seed * 37 + i * 91 + 5) & 8'hFF);
      if (d[i] == SYNC) d[i] = d[i] ^ 8'h01;
      ce[i] = 1'b1;
      if (sync_mid && i == 1) begin
        d[i]  = SYNC;
        ce[i] = (seed % 2 == 0);
      end
      if (ce[i]) c = crc_model(c, d[i]);
    end
    for (int i = 0; i < n; i++) begin
      write_byte(d[i], ce[i]);
      if (i == 0 && clr) begin
        eom_clr = 1'b1; @(negedge clk); eom_clr = 1'b0; @(negedge clk);
        chk(eom_o == 1'b0, "R8", "eom clear while enabled", eom_o, 0);
      end
    end
    cycles(7 * 32);
    while (idx < rxb.size() && rxb[idx] == SYNC) idx++;
    chk(idx >= 1, "R2", "leading sync count", idx, 1);
    if (rxb.size() < idx + n + (clr ? 3 : 1)) begin
      chk(1'b0, "R4", "stream too short", rxb.size(), idx + n + 3);
    end else begin
      for (int i = 0; i < n; i++)
        chk(rxb[idx+i] == d[i], "R4", "data byte", rxb[idx+i], d[i]);
      idx += n;
      if (clr) begin
        chk(rxb[idx]   == ~c[15:8], "R6", "crc high byte", rxb[idx], ~c[15:8]);
        chk(rxb[idx+1] == ~c[7:0],  "R5", "crc low byte",  rxb[idx+1], ~c[7:0]);
        chk(rxb[idx+2] == SYNC,     "R6", "sync after crc", rxb[idx+2], SYNC);
      end else begin
        chk(rxb[idx] == SYNC, "R7", "sync after data", rxb[idx], SYNC);
      end
    end
    chk(eom_o == 1'b1, "R6", "eom set after underrun", eom_o, 1);
    chk(irq_cnt == ((clr && ie) ? 1 : 0), "R9", "irq pulse count", irq_cnt, (clr && ie) ? 1 : 0);
  endtask

  initial begin
    rst_ni = 1'b0; tx_en = 1'b0; wr = 1'b0; wr_data = '0; crc_en = 1'b1;
    eom_clr = 1'b0; irq_en = 1'b1; sync_char = SYNC;
    cycles(3);
    chk(txd_o == 1'b1,       "R1", "reset txd",  txd_o, 1);
    chk(buf_empty_o == 1'b1, "R1", "reset empty", buf_empty_o, 1);
    chk(eom_o == 1'b1,       "R1", "reset eom",  eom_o, 1);
    chk(irq_o == 1'b0,       "R1", "reset irq",  irq_o, 0);
    rst_ni = 1'b1;
    cycles(2);

    // R3: write while disabled is dropped
    wr = 1'b1; wr_data = 8'hA5; @(negedge clk); wr = 1'b0; @(negedge clk);
    chk(buf_empty_o == 1'b1, "R3", "write while disabled", buf_empty_o, 1);
    chk(txd_o == 1'b1,       "R1", "idle line disabled",   txd_o, 1);

    // R2: sync fill
    rxb.delete(); tx_en = 1'b1;
    cycles(4 * 32);
    chk(rxb.size() >= 3, "R2", "sync fill count", rxb.size(), 3);
    foreach (rxb[i]) chk(rxb[i] == SYNC, "R2", "sync fill byte", rxb[i], SYNC);

    // R3: second write into full buffer is dropped
    @(negedge clk); #1;
    while (!bit_en) begin @(negedge clk); #1; end
    rxb.delete();
    @(negedge clk); wr = 1'b1; wr_data = 8'h51; crc_en = 1'b1;
    @(negedge clk); wr_data = 8'h62;
    @(negedge clk); wr = 1'b0;
    chk(buf_empty_o == 1'b0, "R3", "buffer holds write", buf_empty_o, 0);
    cycles(6 * 32);
    begin
      int idx = 0;
      while (idx < rxb.size() && rxb[idx] == SYNC) idx++;
      if (idx + 1 < rxb.size()) begin
        chk(rxb[idx] == 8'h51,   "R3", "first write kept",    rxb[idx], 8'h51);
        chk(rxb[idx+1] == SYNC,  "R3", "second write dropped", rxb[idx+1], SYNC);
      end else begin
        chk(1'b0, "R3", "stream too short", rxb.size(), idx + 2);
      end
    end

    // sweep lengths and latch handling
    for (int n = 1; n <= 4; n++)
      for (int clr = 0; clr < 2; clr++)
        msg(n, n * 3 + clr, clr[0], 1'b1, n >= 3);
    msg(3, 6, 1'b1, 1'b1, 1'b1);   // sync byte included (even seed)
    msg(3, 7, 1'b1, 1'b1, 1'b1);   // sync byte excluded (odd seed)
    msg(2, 9, 1'b1, 1'b0, 1'b0);   // interrupt masked

    // R8: clear ignored while disabled
    tx_en = 1'b0; cycles(2);
    eom_clr = 1'b1; @(negedge clk); eom_clr = 1'b0; @(negedge clk);
    chk(eom_o == 1'b1, "R8", "clear ignored disabled", eom_o, 1);
    chk(irq_o == 1'b0, "R9", "no irq when idle",       irq_o, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R4 watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule